// File: doc/BRIEF.md
# Dual-Channel Converter Serial Register Front-End

This block is the digital control logic of a two-channel, 12-bit voltage-output converter. A host sends 24-bit frames over a three-wire serial link: an active-low frame select, a serial clock and a data line. Data is shifted in on falling serial-clock edges. After the last bit the frame is decoded into a command. The command can write a channel's input register, copy input registers into the converter (DAC) registers, set a power-down mode, mask the hardware load strobe, switch the internal reference, or reset the block by software.

Each channel is double-buffered. Values staged in the input registers reach the DAC registers through a command or through the active-low load strobe, and both channels move in the same clock cycle. An active-low clear input zeroes every register stage and aborts any frame in progress. All serial and control pins are resynchronised into one system clock, and every register update happens in that domain.

Top module: `dac_frontend`

## Requirements
- R1: A frame is 24 bits, MSB first, sampled on falling serial-clock edges while the frame select is low. Bits 21:19 hold the command, bits 18:16 the address and bits 15:4 the 12-bit code. The frame takes effect at the 24th falling edge, and any further edges before the select rises are ignored.
- R2: If the frame select rises before the 24th falling edge, the partial frame changes no register.
- R3: Command 000 writes the code into the input register of each addressed channel and leaves the DAC registers unchanged.
- R4: Address 000 selects channel A, 001 selects channel B and 111 selects both; any other address selects none. Command 001 copies input to DAC for the addressed channels. Command 010 writes the addressed input registers and then updates every DAC register. Command 011 writes both stages of the addressed channels.
- R5: While the load strobe is low, every unmasked channel's DAC register follows its input register, so a low pulse updates both channels in the same cycle and a strobe held low updates automatically.
- R6: Command 110 sets the per-channel load-strobe mask from bits 1:0 (bit 0 is A, bit 1 is B). A masked channel ignores the strobe.
- R7: A falling edge on the clear input zeroes every input and DAC register and aborts the frame in progress, so the rest of that frame has no effect.
- R8: While the clear input is held low, the load strobe has no effect.
- R9: Command 100 sets the 2-bit power-down mode from bits 5:4 on each channel whose select bit (bits 1:0, bit 0 is A) is set. The mode output carries A in bits 1:0 and B in bits 3:2. The modes are 00 normal, 01 1k to ground, 10 100k to ground and 11 tri-state.
- R10: Command 111 sets the reference-enable output from bit 0.
- R11: Command 101 restores the power-on state: codes zero, both modes 00, reference off and mask cleared.
- R12: After reset both codes are zero, both modes are 00 and the reference is off.
- R13: Each output change appears on the third system-clock edge after the edge that first samples the pin change that causes it.

Top module code output `dac_code` carries channel A in bits 11:0 and channel B in bits 23:12.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset |
| ser_clk | input | 1 | Serial clock, data taken on falling edges |
| ser_frm_n | input | 1 | Active-low frame select |
| ser_dat | input | 1 | Serial data, MSB first |
| ld_n | input | 1 | Active-low load strobe |
| clr_n | input | 1 | Active-low clear, falling-edge acting |
| dac_code | output | 24 | DAC register codes, A in 11:0, B in 23:12 |
| pd_mode | output | 4 | Power-down modes, A in 1:0, B in 3:2 |
| ref_en | output | 1 | Internal reference enable |

## Verification
The assertions check on every cycle that a clear event leaves both register stages at zero, and that input registers change only on a decoded frame or a clear. They also check that the DAC registers stay still while clear is held, that mode and reference outputs move only on frames, and that frame events never come back to back. The bench scenarios are needed for the command decode, address selection, masking, partial and overlong frames, and aborts in mid-frame. Only the bench's reference model, compared every clock, shows the exact three-cycle latency.

// File: rtl/dac_fe_pkg.sv
package dac_fe_pkg;
   localparam int FRAME_W  = 24;
   localparam int PAY_W    = FRAME_W - 2;
   localparam int CMD_MSB  = 21;
   localparam int CMD_LSB  = 19;
   localparam int ADDR_MSB = 18;
   localparam int ADDR_LSB = 16;
   localparam int CODE_MSB = 15;
   localparam int MODE_LSB = 4;
   localparam logic [2:0] ADDR_ALL = 3'b111;

   typedef enum logic [2:0] {
      CMD_WR_IN      = 3'd0,
      CMD_UPD        = 3'd1,
      CMD_WR_UPD_ALL = 3'd2,
      CMD_WR_UPD     = 3'd3,
      CMD_PWRDN      = 3'd4,
      CMD_SWRST      = 3'd5,
      CMD_LDMASK     = 3'd6,
      CMD_REF        = 3'd7
   } cmd_e;
endpackage

// File: rtl/dac_in_sync.sv
module dac_in_sync #(
   parameter int          N       = 5,
   parameter int          STAGES  = 2,
   parameter logic [N-1:0] RST_VAL = '1
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [N-1:0] pin,
   output logic [N-1:0] lvl,
   output logic [N-1:0] fall,
   output logic [N-1:0] rise
);
   generate
      if (STAGES < 2) begin : g_bad_stages
         $error("dac_in_sync: STAGES must be at least 2");
      end
      for (genvar i = 0; i < N; i++) begin : g_bit
         logic [STAGES:0] sh;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) sh <= {(STAGES+1){RST_VAL[i]}};
            else        sh <= {sh[STAGES-1:0], pin[i]};
         end
         assign lvl[i]  = sh[STAGES-1];
         assign fall[i] = sh[STAGES] & ~sh[STAGES-1];
         assign rise[i] = ~sh[STAGES] & sh[STAGES-1];
      end
   endgenerate
endmodule

// File: rtl/dac_frame_rx.sv
module dac_frame_rx
   import dac_fe_pkg::*;
(
   input  logic             clk,
   input  logic             rst_n,
   input  logic             sclk_fall,
   input  logic             frm_lvl,
   input  logic             frm_fall,
   input  logic             frm_rise,
   input  logic             din,
   input  logic             clr_lvl,
   input  logic             clr_fall,
   input  logic             ld_lvl,
   output logic             ev_frame,
   output logic [PAY_W-1:0] frame,
   output logic             ev_clear,
   output logic             clr_hold,
   output logic             ld_act
);
   localparam int CNT_W = $clog2(FRAME_W);
   localparam logic [CNT_W-1:0] LAST = CNT_W'(FRAME_W - 1);

   logic [CNT_W-1:0] cnt;
   logic             armed;
   logic [PAY_W-2:0] sr;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt      <= '0;
         armed    <= 1'b0;
         sr       <= '0;
         frame    <= '0;
         ev_frame <= 1'b0;
         ev_clear <= 1'b0;
         clr_hold <= 1'b0;
         ld_act   <= 1'b0;
      end else begin
         ev_frame <= 1'b0;
         ev_clear <= clr_fall;
         clr_hold <= ~clr_lvl;
         ld_act   <= ~ld_lvl;
         if (clr_fall || frm_rise) begin
            armed <= 1'b0;
         end else if (frm_fall) begin
            armed <= 1'b1;
            cnt   <= '0;
         end else if (armed && sclk_fall && !frm_lvl) begin
            sr  <= {sr[PAY_W-3:0], din};
            cnt <= cnt + 1'b1;
            if (cnt == LAST) begin
               armed    <= 1'b0;
               ev_frame <= 1'b1;
               frame    <= {sr, din};
            end
         end
      end
   end
endmodule

// File: rtl/dac_chan_bank.sv
module dac_chan_bank
   import dac_fe_pkg::*;
#(
   parameter int CH_N   = 2,
   parameter int CODE_W = 12
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     ev_frame,
   input  logic [PAY_W-1:0]         frame,
   input  logic                     ev_clear,
   input  logic                     clr_hold,
   input  logic                     ld_act,
   output logic [CH_N*CODE_W-1:0]   inp_flat,
   output logic [CH_N*CODE_W-1:0]   dac_flat,
   output logic [2*CH_N-1:0]        pd_flat,
   output logic                     ref_en
);
   generate
      if (CH_N < 1 || CH_N > 4) begin : g_bad_ch
         $error("dac_chan_bank: CH_N must be 1 to 4");
      end
      if (CODE_W < 1 || CODE_W > 12) begin : g_bad_code
         $error("dac_chan_bank: CODE_W must be 1 to 12");
      end
   endgenerate

   cmd_e              cmd;
   logic [2:0]        addr;
   logic [CODE_W-1:0] code;
   logic              is_rst;
   logic              upd_all;

   assign cmd     = cmd_e'(frame[CMD_MSB:CMD_LSB]);
   assign addr    = frame[ADDR_MSB:ADDR_LSB];
   assign code    = frame[CODE_MSB -: CODE_W];
   assign is_rst  = ev_frame && (cmd == CMD_SWRST);
   assign upd_all = ev_frame && (cmd == CMD_WR_UPD_ALL);

   logic unused_bits;
   assign unused_bits = ^{frame[PAY_W-1:CMD_MSB+1], frame[3:0]};

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                              ref_en <= 1'b0;
      else if (is_rst)                         ref_en <= 1'b0;
      else if (ev_frame && (cmd == CMD_REF))   ref_en <= frame[0];
   end

   for (genvar c = 0; c < CH_N; c++) begin : g_ch
      logic [CODE_W-1:0] inp_q, dac_q, inp_n, dac_n;
      logic [1:0]        pd_q;
      logic              mask_q;
      logic              sel, wr, upd, ld_copy, zero;

      assign sel     = (addr == ADDR_ALL) || (addr == 3'(c));
      assign wr      = ev_frame && sel &&
                       (cmd == CMD_WR_IN || cmd == CMD_WR_UPD_ALL || cmd == CMD_WR_UPD);
      assign upd     = upd_all ||
                       (ev_frame && sel && (cmd == CMD_UPD || cmd == CMD_WR_UPD));
      assign ld_copy = ld_act && !clr_hold && !mask_q;
      assign zero    = ev_clear || is_rst;

      always_comb begin
         inp_n = inp_q;
         dac_n = dac_q;
         if (zero) begin
            inp_n = '0;
            dac_n = '0;
         end else begin
            if (wr)             inp_n = code;
            if (upd || ld_copy) dac_n = inp_n;
         end
      end

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            inp_q  <= '0;
            dac_q  <= '0;
            pd_q   <= 2'b00;
            mask_q <= 1'b0;
         end else begin
            inp_q <= inp_n;
            dac_q <= dac_n;
            if (is_rst) begin
               pd_q   <= 2'b00;
               mask_q <= 1'b0;
            end else if (ev_frame) begin
               if (cmd == CMD_PWRDN && frame[c]) pd_q <= frame[MODE_LSB+1:MODE_LSB];
               if (cmd == CMD_LDMASK)            mask_q <= frame[c];
            end
         end
      end

      assign inp_flat[c*CODE_W +: CODE_W] = inp_q;
      assign dac_flat[c*CODE_W +: CODE_W] = dac_q;
      assign pd_flat[2*c +: 2]            = pd_q;
   end
endmodule

// File: rtl/dac_frontend.sv
module dac_frontend
   import dac_fe_pkg::*;
#(
   parameter int CH_N        = 2,
   parameter int CODE_W      = 12,
   parameter int SYNC_STAGES = 2
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   ser_clk,
   input  logic                   ser_frm_n,
   input  logic                   ser_dat,
   input  logic                   ld_n,
   input  logic                   clr_n,
   output logic [CH_N*CODE_W-1:0] dac_code,
   output logic [2*CH_N-1:0]      pd_mode,
   output logic                   ref_en
);
   localparam int PIN_N = 5;
   localparam int P_SCLK = 0, P_FRM = 1, P_DAT = 2, P_LD = 3, P_CLR = 4;
   localparam logic [PIN_N-1:0] PIN_IDLE = 5'b11011;

   logic [PIN_N-1:0] pin_lvl, pin_fall, pin_rise;
   logic             ev_frame, ev_clear, clr_hold, ld_act;
   logic [PAY_W-1:0] frame;
   logic [CH_N*CODE_W-1:0] inp_flat;

   dac_in_sync #(.N(PIN_N), .STAGES(SYNC_STAGES), .RST_VAL(PIN_IDLE)) u_sync (
      .clk  (clk),
      .rst_n(rst_n),
      .pin  ({clr_n, ld_n, ser_dat, ser_frm_n, ser_clk}),
      .lvl  (pin_lvl),
      .fall (pin_fall),
      .rise (pin_rise)
   );

   logic unused_sync;
   assign unused_sync = ^{pin_lvl[P_SCLK], pin_fall[P_DAT], pin_fall[P_LD],
                          pin_rise[P_SCLK], pin_rise[P_DAT], pin_rise[P_LD], pin_rise[P_CLR]};

   dac_frame_rx u_rx (
      .clk      (clk),
      .rst_n    (rst_n),
      .sclk_fall(pin_fall[P_SCLK]),
      .frm_lvl  (pin_lvl[P_FRM]),
      .frm_fall (pin_fall[P_FRM]),
      .frm_rise (pin_rise[P_FRM]),
      .din      (pin_lvl[P_DAT]),
      .clr_lvl  (pin_lvl[P_CLR]),
      .clr_fall (pin_fall[P_CLR]),
      .ld_lvl   (pin_lvl[P_LD]),
      .ev_frame (ev_frame),
      .frame    (frame),
      .ev_clear (ev_clear),
      .clr_hold (clr_hold),
      .ld_act   (ld_act)
   );

   dac_chan_bank #(.CH_N(CH_N), .CODE_W(CODE_W)) u_bank (
      .clk     (clk),
      .rst_n   (rst_n),
      .ev_frame(ev_frame),
      .frame   (frame),
      .ev_clear(ev_clear),
      .clr_hold(clr_hold),
      .ld_act  (ld_act),
      .inp_flat(inp_flat),
      .dac_flat(dac_code),
      .pd_flat (pd_mode),
      .ref_en  (ref_en)
   );
endmodule

// File: rtl/dac_fe_chk.sv
module dac_fe_chk #(
   parameter int CH_N   = 2,
   parameter int CODE_W = 12
) (
   input logic                   clk,
   input logic                   rst_n,
   input logic                   ev_frame,
   input logic                   ev_clear,
   input logic                   clr_hold,
   input logic [CH_N*CODE_W-1:0] inp,
   input logic [CH_N*CODE_W-1:0] dac,
   input logic [2*CH_N-1:0]      pd,
   input logic                   ref_en
);
   a_r7_clear_zero: assert property (@(posedge clk) disable iff (!rst_n)
      ev_clear |=> (dac == '0 && inp == '0));

   a_r2_inp_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (!ev_frame && !ev_clear) |=> $stable(inp));

   a_r8_clr_blocks: assert property (@(posedge clk) disable iff (!rst_n)
      (clr_hold && !ev_frame && !ev_clear) |=> $stable(dac));

   a_r9_pd_hold: assert property (@(posedge clk) disable iff (!rst_n)
      !ev_frame |=> $stable(pd));

   a_r10_ref_hold: assert property (@(posedge clk) disable iff (!rst_n)
      !ev_frame |=> $stable(ref_en));

   a_r1_frame_spacing: assert property (@(posedge clk) disable iff (!rst_n)
      ev_frame |=> !ev_frame);
endmodule

bind dac_frontend dac_fe_chk #(.CH_N(CH_N), .CODE_W(CODE_W)) u_chk (
   .clk     (clk),
   .rst_n   (rst_n),
   .ev_frame(ev_frame),
   .ev_clear(ev_clear),
   .clr_hold(clr_hold),
   .inp     (inp_flat),
   .dac     (dac_code),
   .pd      (pd_mode),
   .ref_en  (ref_en)
);

// File: tb/sim_dac_frontend.sv
module sim_dac_frontend;
   localparam int CLK_PERIOD = 10;
   localparam int H = 4;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic ser_clk = 1'b1, ser_frm_n = 1'b1, ser_dat = 1'b0, ld_n = 1'b1, clr_n = 1'b1;
   logic [23:0] dac_code;
   logic [3:0]  pd_mode;
   logic        ref_en;

   always #(CLK_PERIOD/2) clk = ~clk;

   dac_frontend u0 (
      .clk(clk), .rst_n(rst_n), .ser_clk(ser_clk), .ser_frm_n(ser_frm_n),
      .ser_dat(ser_dat), .ld_n(ld_n), .clr_n(clr_n),
      .dac_code(dac_code), .pd_mode(pd_mode), .ref_en(ref_en)
   );

   int checks = 0, fails = 0;
   bit done = 0, run = 0;
   string cur_req = "R12";

   // behavioural reference model
   logic [11:0] m_inp [2];
   logic [11:0] m_dac [2];
   logic [1:0]  m_pd [2];
   logic [1:0]  m_mask;
   logic        m_ref;
   logic [28:0] hist [4];

   function automatic logic [28:0] m_pack();
      return {m_ref, m_pd[1], m_pd[0], m_dac[1], m_dac[0]};
   endfunction

   task automatic m_zero_all();
      for (int c = 0; c < 2; c++) begin m_inp[c] = 0; m_dac[c] = 0; end
   endtask

   task automatic m_settle();
      if (!ld_n && clr_n)
         for (int c = 0; c < 2; c++) if (!m_mask[c]) m_dac[c] = m_inp[c];
   endtask

   task automatic m_apply(input logic [23:0] f);
      int cmd, ad;
      cmd = f[21:19];
      ad  = f[18:16];
      for (int c = 0; c < 2; c++) begin
         bit hit;
         hit = (ad == 7) || (ad == c);
         case (cmd)
            0: if (hit) m_inp[c] = f[15:4];
            1: if (hit) m_dac[c] = m_inp[c];
            2: if (hit) m_inp[c] = f[15:4];
            3: if (hit) begin m_inp[c] = f[15:4]; m_dac[c] = f[15:4]; end
            4: if (f[c]) m_pd[c] = f[5:4];
            5: begin m_inp[c] = 0; m_dac[c] = 0; m_pd[c] = 0; end
            6: m_mask[c] = f[c];
            default: ;
         endcase
      end
      if (cmd == 2) for (int c = 0; c < 2; c++) m_dac[c] = m_inp[c];
      if (cmd == 5) begin m_ref = 0; m_mask = 0; end
      if (cmd == 7) m_ref = f[0];
      m_settle();
   endtask

   initial begin
      m_zero_all();
      m_pd[0] = 0; m_pd[1] = 0; m_mask = 0; m_ref = 0;
      for (int i = 0; i < 4; i++) hist[i] = '0;
   end

   always @(posedge clk) begin
      hist[3] <= hist[2];
      hist[2] <= hist[1];
      hist[1] <= hist[0];
      hist[0] <= m_pack();
   end

   // R13: per-cycle comparison against the model delayed by three clocks
   always @(negedge clk) begin
      if (run && !done) begin
         checks++;
         if ({ref_en, pd_mode, dac_code} !== hist[3]) begin
            fails++;
            $display("FAIL %s/R13 cycle compare: actual %h expected %h",
                     cur_req, {ref_en, pd_mode, dac_code}, hist[3]);
         end
      end
   end

   task automatic finish_up();
      if (!done) begin
         done = 1;
         $display("%0d/%0d checks passed", checks - fails, checks);
         $finish;
      end
   endtask

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s: actual %h expected %h", tag, act, exp);
      end
   endtask

   task automatic wait_n(input int n);
      repeat (n) @(negedge clk);
   endtask

   function automatic logic [23:0] mk(input logic [2:0] cmd, input logic [2:0] ad,
                                      input logic [15:0] pay);
      return {2'b00, cmd, ad, pay};
   endfunction

   // nbits: bits sent; clr_at: bit index before which clear pulses (-1 none)
   task automatic send(input logic [23:0] f, input int nbits, input int clr_at, input int extra);
      bit aborted = 0;
      ser_frm_n = 0;
      wait_n(H);
      for (int i = 0; i < nbits + extra; i++) begin
         if (i == clr_at) begin
            clr_n = 0; m_zero_all(); aborted = 1;
            wait_n(H);
            clr_n = 1; m_settle();
            wait_n(H);
         end
         ser_dat = (i < 24) ? f[23-i] : 1'b1;
         wait_n(H);
         ser_clk = 0;
         if (i == 23 && !aborted) m_apply(f);
         wait_n(H);
         ser_clk = 1;
      end
      wait_n(H);
      ser_frm_n = 1;
      wait_n(2*H);
   endtask

   task automatic ld_pulse();
      ld_n = 0; m_settle();
      wait_n(H);
      ld_n = 1;
      wait_n(2*H);
   endtask

   initial begin
      wait_n(5);
      rst_n = 1;
      run = 1;
      wait_n(4);
      // R12 reset state
      chk("R12 codes", 32'(dac_code), 0);
      chk("R12 modes", 32'(pd_mode), 0);
      chk("R12 ref", 32'(ref_en), 0);

      cur_req = "R3";
      send(mk(3'd0, 3'd0, 16'hABC0), 24, -1, 0);
      wait_n(6);
      chk("R3 write input only", 32'(dac_code), 0);

      cur_req = "R5";
      ld_pulse();
      chk("R5 strobe pulse", 32'(dac_code), 32'h000ABC);

      cur_req = "R4";
      send(mk(3'd3, 3'd1, 16'h1230), 24, -1, 0);
      wait_n(6);
      chk("R4 write+update B", 32'(dac_code), 32'h123ABC);
      send(mk(3'd0, 3'd7, 16'h5550), 24, -1, 0);
      send(mk(3'd1, 3'd0, 16'h0000), 24, -1, 0);
      wait_n(6);
      chk("R4 update A from input", 32'(dac_code), 32'h123555);
      send(mk(3'd2, 3'd1, 16'h7770), 24, -1, 0);
      wait_n(6);
      chk("R4 write B update all", 32'(dac_code), 32'h777555);

      cur_req = "R2";
      send(mk(3'd3, 3'd0, 16'hFFF0), 12, -1, 0);
      wait_n(6);
      chk("R2 partial frame", 32'(dac_code), 32'h777555);

      cur_req = "R1";
      send(mk(3'd3, 3'd0, 16'h0F00), 24, -1, 6);
      wait_n(6);
      chk("R1 extra edges ignored", 32'(dac_code), 32'h7770F0);

      cur_req = "R4";
      send(mk(3'd3, 3'd2, 16'hFFF0), 24, -1, 0);
      wait_n(6);
      chk("R4 unused address", 32'(dac_code), 32'h7770F0);

      cur_req = "R6";
      send(mk(3'd6, 3'd0, 16'h0001), 24, -1, 0);
      send(mk(3'd0, 3'd7, 16'h3210), 24, -1, 0);
      ld_pulse();
      chk("R6 masked channel A", 32'(dac_code), 32'h3210F0);
      send(mk(3'd6, 3'd0, 16'h0000), 24, -1, 0);

      cur_req = "R5";
      ld_n = 0; m_settle();
      wait_n(8);
      chk("R5 held strobe copies", 32'(dac_code), 32'h321321);
      send(mk(3'd0, 3'd0, 16'h9AB0), 24, -1, 0);
      wait_n(6);
      chk("R5 automatic update", 32'(dac_code), 32'h3219AB);
      ld_n = 1;
      wait_n(4);

      cur_req = "R7";
      clr_n = 0; m_zero_all();
      wait_n(8);
      chk("R7 clear zeroes", 32'(dac_code), 0);
      cur_req = "R8";
      send(mk(3'd0, 3'd0, 16'h4440), 24, -1, 0);
      ld_pulse();
      wait_n(4);
      chk("R8 strobe ignored in clear", 32'(dac_code), 0);
      clr_n = 1; m_settle();
      wait_n(4);
      ld_pulse();
      chk("R8 strobe after release", 32'(dac_code), 32'h000444);

      cur_req = "R7";
      send(mk(3'd3, 3'd1, 16'h2AA0), 24, -1, 0);
      send(mk(3'd3, 3'd0, 16'hEEE0), 24, 10, 0);
      wait_n(6);
      chk("R7 abort in mid-frame", 32'(dac_code), 0);

      cur_req = "R9";
      send(mk(3'd4, 3'd0, 16'h0022), 24, -1, 0);
      wait_n(6);
      chk("R9 mode B only", 32'(pd_mode), 32'h8);
      send(mk(3'd4, 3'd0, 16'h0033), 24, -1, 0);
      send(mk(3'd4, 3'd0, 16'h0001), 24, -1, 0);
      wait_n(6);
      chk("R9 modes both then A normal", 32'(pd_mode), 32'hC);

      cur_req = "R10";
      send(mk(3'd7, 3'd0, 16'h0001), 24, -1, 0);
      wait_n(6);
      chk("R10 reference on", 32'(ref_en), 1);

      cur_req = "R11";
      send(mk(3'd3, 3'd7, 16'hABC0), 24, -1, 0);
      send(mk(3'd6, 3'd0, 16'h0003), 24, -1, 0);
      send(mk(3'd5, 3'd0, 16'h0000), 24, -1, 0);
      wait_n(6);
      chk("R11 codes", 32'(dac_code), 0);
      chk("R11 modes", 32'(pd_mode), 0);
      chk("R11 reference", 32'(ref_en), 0);
      send(mk(3'd0, 3'd7, 16'h1110), 24, -1, 0);
      ld_pulse();
      chk("R11 mask cleared", 32'(dac_code), 32'h111111);

      wait_n(6);
      finish_up();
   end

   initial begin
      repeat (200000) @(posedge clk);
      checks++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_up();
   end
endmodule